// File: doc/BRIEF.md
# Latched Interrupt Controller with Mask

This block sits next to a processor core and gathers up to 32 interrupt lines into one request. Each line passes through a synchronizer. It then raises a pending bit in a status register, either on a rising edge or for as long as the line is high, depending on a per-line build-time sense vector. Level lines are latched too. A pending bit stays set after its source drops, until software clears it.

Software reaches two registers through a small special-register port: an enable mask and the pending status word. The mask is plain read/write. Status writes can only clear bits. A build-time parameter picks the clear rule. In the default rule a 1 in the write data clears that bit. In the legacy rule a 0 clears it, so software clears one line by writing back the status word with that single bit zeroed. The core sees a registered request that is high while any enabled bit is pending. It also sees the index of the lowest enabled pending line, so it can serve lines in ascending order.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While reset is asserted, the mask reads as 0, the status reads as 0, and `irq_req` and `irq_id_valid` are 0.
- R2: A write with `reg_sel`=0 loads `reg_wdata` into the mask. Reads with `reg_sel`=0 return the mask combinationally. A mask bit of 1 enables its line.
- R3: On an edge line (`EDGE_MASK` bit = 1), a 0-to-1 change of the input sets its status bit on the third rising clock edge that samples the new value. A line held high after it is cleared does not set the bit again.
- R4: On a level line (`EDGE_MASK` bit = 0), a high input sets its status bit with the same latency. The bit stays set after the input falls, until it is cleared.
- R5: With `CLEAR_MODE`=CLR_ON_ONE, a write with `reg_sel`=1 clears each status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: With `CLEAR_MODE`=CLR_ON_ZERO, a write with `reg_sel`=1 clears each status bit whose write-data bit is 0 and leaves the bits written as 1 unchanged.
- R7: When a line's set event and a clear of that bit fall in the same cycle, the bit ends up set.
- R8: `irq_req` is the OR of (status AND mask), registered one clock after those registers.
- R9: `irq_id` is the lowest index i with status[i] AND mask[i] set, and `irq_id_valid` is 1 exactly when such an index exists. Both are combinational.
- R10: Masking does not stop latching. A disabled line's event still shows in the status read, but it drives neither `irq_req` nor `irq_id_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_LINES | Raw interrupt lines |
| reg_sel | input | 1 | Register select: 0 mask, 1 status |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | N_LINES | Write data |
| reg_rdata | output | N_LINES | Read data of the selected register |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | $clog2(N_LINES) | Lowest enabled pending line |
| irq_id_valid | output | 1 | `irq_id` is meaningful |

## Verification
A wrong status bit shows up in the status read in the same cycle it is wrong. If that bit is enabled, it also shows one clock later on `irq_req`, and in the same cycle on `irq_id`. An edge detector that fires again on a held line shows up as a bit that comes back after a clear. A missing latch on a level line shows up as a bit that disappears once the input falls. Each register-port access is followed within a cycle by a read, so a wrong clear rule or a lost set-versus-clear collision is caught at the next status read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Register select encoding on the special-register port
  typedef enum logic {
    SEL_MASK   = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;

  // Status clear rule, picked at build time
  typedef enum logic {
    CLR_ON_ONE  = 1'b0,
    CLR_ON_ZERO = 1'b1
  } clr_mode_e;

endpackage

// File: rtl/irqc_sync.sv
// Per-line synchronizer followed by the edge or level event former.
module irqc_sync #(
  parameter int                 N_LINES     = 32,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [N_LINES-1:0] EDGE_MASK   = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] raw_in,
  output logic [N_LINES-1:0] event_vec
);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [SYNC_STAGES-1:0] shreg;
    logic                   synced;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[SYNC_STAGES-2:0], raw_in[i]};
    end
    assign synced = shreg[SYNC_STAGES-1];

    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= synced;
      end
      assign event_vec[i] = synced & ~prev_q;
    end else begin : g_level
      assign event_vec[i] = synced;
    end
  end

endmodule

// File: rtl/irqc_status.sv
// Pending-status register: events set bits, software writes only clear.
module irqc_status
  import irqc_pkg::*;
#(
  parameter int        N_LINES    = 32,
  parameter clr_mode_e CLEAR_MODE = CLR_ON_ONE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] set_vec,
  input  logic               wr_en,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] status_q
);

  function automatic logic [N_LINES-1:0] clear_bits(
    input logic en, input logic [N_LINES-1:0] data);
    if (!en) return '0;
    return (CLEAR_MODE == CLR_ON_ZERO) ? ~data : data;
  endfunction

  logic [N_LINES-1:0] clr_vec;
  assign clr_vec = clear_bits(wr_en, wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_vec;
  end

  // A bit only rises after an event on its line (R3, R4)
  assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

  // An event always leaves its bit set, even against a clear (R7)
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_vec) & ~status_q) == '0));

  // A cleared bit without a competing event goes to zero (R5, R6)
  assert_clear_honoured_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr_vec & ~set_vec) & status_q) == '0));

endmodule

// File: rtl/irqc_lowest.sv
// Lowest-index encoder over the enabled pending vector.
module irqc_lowest #(
  parameter int N_LINES = 32,
  localparam int ID_W   = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pend_vec,
  output logic [ID_W-1:0]    low_id,
  output logic               low_valid
);

  function automatic logic [ID_W:0] find_lowest(input logic [N_LINES-1:0] v);
    logic [ID_W:0] r;
    r = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, ID_W'(i)};
    end
    return r;
  endfunction

  assign {low_valid, low_id} = find_lowest(pend_vec);

  // The reported line is pending and nothing below it is (R9)
  assert_lowest_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    low_valid |-> (pend_vec[low_id] &&
                   ((pend_vec & ((N_LINES'(1) << low_id) - N_LINES'(1))) == '0)));

  assert_valid_iff_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (low_valid == (pend_vec != '0)));

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irqc_pkg::*;
#(
  parameter int                 N_LINES     = 32,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [N_LINES-1:0] EDGE_MASK   = N_LINES'(32'h0000_FFFF),
  parameter clr_mode_e          CLEAR_MODE  = CLR_ON_ONE,
  localparam int                ID_W        = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               irq_req,
  output logic [ID_W-1:0]    irq_id,
  output logic               irq_id_valid
);

  logic [N_LINES-1:0] event_vec;
  logic [N_LINES-1:0] status_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] pend_vec;
  logic               mask_wr;
  logic               status_wr;
  logic               enc_valid;
  logic [ID_W-1:0]    enc_id;

  assign mask_wr   = reg_we && (reg_sel == logic'(SEL_MASK));
  assign status_wr = reg_we && (reg_sel == logic'(SEL_STATUS));

  irqc_sync #(
    .N_LINES    (N_LINES),
    .SYNC_STAGES(SYNC_STAGES),
    .EDGE_MASK  (EDGE_MASK)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (irq_in),
    .event_vec(event_vec)
  );

  irqc_status #(
    .N_LINES   (N_LINES),
    .CLEAR_MODE(CLEAR_MODE)
  ) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (event_vec),
    .wr_en   (status_wr),
    .wr_data (reg_wdata),
    .status_q(status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= reg_wdata;
  end

  assign pend_vec = status_q & mask_q;

  irqc_lowest #(
    .N_LINES(N_LINES)
  ) u_lowest (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_vec (pend_vec),
    .low_id   (enc_id),
    .low_valid(enc_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= |pend_vec;
  end

  assign reg_rdata    = (reg_sel == logic'(SEL_STATUS)) ? status_q : mask_q;
  assign irq_id       = enc_id;
  assign irq_id_valid = enc_valid;

  // Mask takes the written word on the next edge (R2)
  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_wr) && $past(rst_n)) |-> (mask_q == $past(reg_wdata)));

  // Mask holds when not written (R2)
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!mask_wr) && $past(rst_n)) |-> $stable(mask_q));

  // Request trails the encoder's valid by one cycle (R8)
  assert_req_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req == $past(enc_valid)));

  // A masked-off event never reaches the core side (R10)
  assert_masked_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !enc_valid);

endmodule

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;
  import irqc_pkg::*;

  localparam int          N    = 32;
  localparam logic [31:0] EDGE = 32'h0000_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] wdata_z;
  logic [31:0] rdata_a, rdata_b;
  logic        req_a, req_b, val_a, val_b;
  logic [4:0]  id_a, id_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit finishing = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  // Legacy-rule instance sees inverted status write data, so both clear the same bits
  assign wdata_z = reg_sel ? ~reg_wdata : reg_wdata;

  irq_latch_ctrl #(.N_LINES(N), .EDGE_MASK(EDGE), .CLEAR_MODE(CLR_ON_ONE)) i_irq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .irq_req(req_a), .irq_id(id_a),
    .irq_id_valid(val_a));

  irq_latch_ctrl #(.N_LINES(N), .EDGE_MASK(EDGE), .CLEAR_MODE(CLR_ON_ZERO)) i_irq_latch_ctrl_w0c (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(wdata_z), .reg_rdata(rdata_b), .irq_req(req_b), .irq_id(id_b),
    .irq_id_valid(val_b));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Bench view of the requirements
  function automatic logic [31:0] events_of(input logic [31:0] s, input logic [31:0] p);
    return (s & ~p & EDGE) | (s & ~EDGE);
  endfunction

  function automatic logic [5:0] lowest_of(input logic [31:0] v);
    int k;
    k = 0;
    while (k < 32 && !v[k]) k++;
    if (k == 32) return 6'd0;
    return {1'b1, 5'(k)};
  endfunction

  logic [31:0] m_s0, m_s1, m_prev, m_stat, m_mask;
  logic        m_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 <= '0; m_s1 <= '0; m_prev <= '0; m_stat <= '0; m_mask <= '0; m_req <= 1'b0;
    end else begin
      m_s0   <= irq_in;
      m_s1   <= m_s0;
      m_prev <= m_s1;
      m_stat <= (m_stat & ~((reg_we && reg_sel) ? reg_wdata : 32'h0)) | events_of(m_s1, m_prev);
      if (reg_we && !reg_sel) m_mask <= reg_wdata;
      m_req  <= |(m_stat & m_mask);
    end
  end

  // Continuous comparison against the model, mid-cycle
  always @(negedge clk) begin
    if (rst_n && !finishing) begin
      logic [31:0] exp_rd;
      logic [5:0]  lo;
      exp_rd = reg_sel ? m_stat : m_mask;
      lo = lowest_of(m_stat & m_mask);
      chk(rdata_a == exp_rd, reg_sel ? "R5 status read" : "R2 mask read", rdata_a, exp_rd);
      chk(rdata_b == (reg_sel ? exp_rd : m_mask), reg_sel ? "R6 status read" : "R2 mask read",
          rdata_b, exp_rd);
      chk(req_a == m_req && req_b == m_req, "R8 request", {req_a, req_b}, {m_req, m_req});
      chk(val_a == lo[5] && val_b == lo[5], "R9 valid", {val_a, val_b}, {lo[5], lo[5]});
      if (lo[5])
        chk(id_a == lo[4:0] && id_b == lo[4:0], "R9 index", {id_a, id_b}, {lo[4:0], lo[4:0]});
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic peek_status(input logic [31:0] exp, input string req);
    reg_sel = 1'b1;
    reg_we  = 1'b0;
    @(negedge clk);
    chk(rdata_a == exp, req, rdata_a, exp);
    chk(rdata_b == exp, req, rdata_b, exp);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  initial begin
    // R1: reset state
    tick(3);
    reg_sel = 1'b0;
    @(negedge clk);
    chk(rdata_a == 0 && rdata_b == 0, "R1 mask in reset", rdata_a, 0);
    chk(req_a == 0 && req_b == 0 && val_a == 0 && val_b == 0, "R1 outputs in reset",
        {req_a, req_b, val_a, val_b}, 0);
    peek_status(32'h0, "R1 status in reset");
    tick(1);
    rst_n = 1'b1;
    tick(1);

    wr(1'b0, 32'hFFFF_FFFF);
    // R3: edge line 3 latency and no re-set while held
    irq_in = 32'h8;
    tick(2);
    peek_status(32'h0, "R3 before third edge");
    tick(1);
    peek_status(32'h8, "R3 set on third edge");
    tick(1);
    chk(req_a == 1 && id_a == 5'd3, "R8 R9 edge line request", {req_a, id_a}, {1'b1, 5'd3});
    wr(1'b1, 32'h8);
    peek_status(32'h0, "R3 held edge not re-set");
    irq_in = '0;
    tick(3);

    // R4: level line 20 stays latched after falling
    irq_in = 32'h0010_0000;
    tick(3);
    peek_status(32'h0010_0000, "R4 level set");
    tick(1);
    irq_in = '0;
    tick(5);
    peek_status(32'h0010_0000, "R4 level latched");
    tick(1);
    wr(1'b1, 32'h0010_0000);
    peek_status(32'h0, "R5 R6 level cleared");
    tick(1);

    // R7: clear while the level event is active loses to the set
    irq_in = 32'h0010_0000;
    tick(3);
    wr(1'b1, 32'h0010_0000);
    peek_status(32'h0010_0000, "R7 set wins");
    tick(1);
    irq_in = '0;
    tick(4);
    wr(1'b1, 32'h0010_0000);
    peek_status(32'h0, "R7 clear after source drop");
    tick(1);

    // R10: masked event latches but stays away from the core
    wr(1'b0, 32'h0);
    irq_in = 32'h80;
    tick(1);
    irq_in = '0;
    tick(3);
    peek_status(32'h80, "R10 masked still latched");
    chk(req_a == 0 && val_a == 0 && req_b == 0 && val_b == 0, "R10 no request",
        {req_a, val_a, req_b, val_b}, 0);
    tick(1);

    // R5 R6: partial clear leaves other bits alone
    irq_in = 32'h0021_0024;
    tick(1);
    irq_in = 32'h0000_0000;
    tick(5);
    wr(1'b1, 32'h0020_0000);
    peek_status(32'h0001_00A4, "R5 R6 partial clear");
    tick(1);
    wr(1'b0, 32'hFFFF_FFFF);
    wr(1'b1, 32'hFFFF_FFFF);

    // Random phase, fixed seed
    void'($urandom(32'd1234));
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = $urandom;
      irq_in = (c % 64 < 32) ? ($urandom & $urandom) : irq_in ^ ($urandom & $urandom & $urandom);
      reg_sel = r[0];
      reg_we  = (r[3:1] == 3'd0);
      reg_wdata = r[0] ? ($urandom & $urandom & $urandom) : $urandom;
      tick(1);
    end
    reg_we = 1'b0;
    tick(2);
    finishing = 1'b1;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      finishing = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule